// File: doc/BRIEF.md
# Audio Clock Divider with Multi-Converter Phase Sync

This block takes a master clock that runs at 256 times the audio sample rate and derives three timing signals from it. The first is a one-cycle enable at 64 times the sample rate that paces a modulator. The second is a bit clock at the same 64x rate. The third is a left/right word clock, with one period per output sample. All three come from one free-running phase counter, so their edges keep a fixed relation to each other.

A converter pin that is active low is also routed into the block. The block samples this pin on the master clock and looks for a low-high-low pulse pattern with bounded widths. When the pattern completes and the block is driving the word clock (master mode), the outputs are parked and the phase counter restarts after a fixed latency. Several converters that share the master clock and receive the same pin waveform therefore produce word clocks in identical phase.

If a pattern is malformed it is dropped, and the running phase is left as it was. A one-cycle flag marks the first word-clock falling edge after a successful realignment.

Top module: `audio_sync_clkgen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets synchronously. After that edge `wclk`, `bclk`, `mod_ce` and `sync_done` are all 0, the phase counter is at zero and any sync sequence in progress is abandoned.
- R2: The phase counter counts up from zero by one per master clock. `wclk` is low for the first 128 master clocks of each 256-clock period (left channel) and high for the next 128.
- R3: `bclk` has a period of 4 master clocks: low for 2, then high for 2. `mod_ce` is high for exactly one master clock in every 4, during the second high cycle of `bclk`.
- R4: `sync_pin_n` is registered once on the master clock. A sequence starts when the registered pin is first 0. The first low phase must last at least 4 sampled clocks. If the pin goes high earlier, the detector returns to idle.
- R5: After the first low phase, the pin must be high for 1 or 2 sampled clocks. A third consecutive high sample aborts the sequence.
- R6: The second low phase must last at least 4 sampled clocks before the pin goes high again. If it is shorter, the sequence is aborted.
- R7: Let edge n be the first rising edge at which the pin is sampled high after a valid second low phase. Then `wclk` and `bclk` stay high and `mod_ce` stays 0 from edge n+1 through edge n+126. Right after edge n+127, `wclk` is low and the phase counter restarts from zero.
- R8: `sync_done` is high for exactly one master clock, in the cycle right after edge n+127, while `wclk` is low.
- R9: When a sequence aborts (R4, R5, R6), no output is parked, `sync_done` stays 0, and every later `wclk` falling edge keeps its original position modulo 256 clocks.
- R10: While `master_en` is 0, the detector stays idle and the pin pattern has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low block reset |
| master_en | input | 1 | 1 when this block drives the word clock; enables sync detection |
| sync_pin_n | input | 1 | Raw active-low sync/reset pin, sampled on `clk` |
| mod_ce | output | 1 | Modulator clock enable, one cycle in every 4 |
| wclk | output | 1 | Left/right word clock, low for the left channel |
| bclk | output | 1 | Bit clock at 64 times the sample rate |
| sync_done | output | 1 | One-cycle pulse on the first word-clock fall after realignment |

## Verification
Some properties are checked by assertions on every cycle:
- the bounds on the detector's counters;
- that the countdown can only be entered from a complete second low phase;
- that the outputs stay quiet while they are parked;
- that `sync_done` is a single pulse that lines up with a low word clock;
- that the detector stays idle in slave mode.

Other properties can only be shown by the bench's scenarios:
- the exact 127-clock release latency;
- the 128/128 word-clock duty cycle after a restart;
- that an aborted pattern leaves the word-clock phase unchanged modulo 256, which the bench shows by comparing the falling-edge positions before and after each pattern.

// File: rtl/audio_sync_pkg.sv
// Package: audio_sync_pkg
// Holds the types shared by the sync detector and the top level.
// Assumes nothing beyond a synthesizable enum encoding.
package audio_sync_pkg;

    // Progress of the low-high-low pin pattern and the release countdown.
    typedef enum logic [2:0] {
        DET_IDLE  = 3'd0,
        DET_LOW1  = 3'd1,
        DET_HIGH  = 3'd2,
        DET_LOW2  = 3'd3,
        DET_COUNT = 3'd4
    } det_state_t;

endpackage

// File: rtl/sync_seq_detect.sv
// Module: sync_seq_detect
// Registers the active-low sync pin once. Then it tracks a first low phase
// of at least LOW_MIN samples, a high phase of HIGH_MIN..HIGH_MAX samples
// and a second low phase of at least LOW_MIN samples. A pattern that breaks
// these bounds returns the detector to idle. When the pattern is complete,
// the divider is parked and a countdown runs. restart_o is raised so that
// the divider restarts exactly SYNC_LATENCY clocks after the edge at which
// the pin was first sampled high.
// Assumes: pin is synchronous to clk; SYNC_LATENCY >= 3; master_en quasi-static.
module sync_seq_detect
    import audio_sync_pkg::*;
#(
    parameter int LOW_MIN      = 4,
    parameter int HIGH_MIN     = 1,
    parameter int HIGH_MAX     = 2,
    parameter int SYNC_LATENCY = 127
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic pin_n,
    output logic hold_o,
    output logic restart_o,
    output logic done_o
);

    localparam int LW = $clog2(LOW_MIN + 1);
    localparam int HW = $clog2(HIGH_MAX + 1);
    localparam int RW = $clog2(SYNC_LATENCY);
    localparam logic [LW-1:0] LOW_SAT   = LW'(LOW_MIN);
    localparam logic [HW-1:0] HIGH_LO   = HW'(HIGH_MIN);
    localparam logic [HW-1:0] HIGH_HI   = HW'(HIGH_MAX);
    localparam logic [RW-1:0] REL_LAST  = RW'(SYNC_LATENCY - 2);

    det_state_t    state_q, state_d;
    logic          pin_q;
    logic [LW-1:0] low_cnt_q, low_cnt_d;
    logic [HW-1:0] high_cnt_q, high_cnt_d;
    logic [RW-1:0] rel_cnt_q, rel_cnt_d;
    logic          done_q;

    // Sample the raw pin; the released (high) level is the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n;
    end

    // Next-state logic of the pattern tracker and release countdown.
    always_comb begin
        state_d    = state_q;
        low_cnt_d  = low_cnt_q;
        high_cnt_d = high_cnt_q;
        rel_cnt_d  = rel_cnt_q;
        if (!master_en) begin
            state_d = DET_IDLE;
        end else begin
            case (state_q)
                DET_IDLE: begin
                    if (!pin_q) begin
                        state_d   = DET_LOW1;
                        low_cnt_d = LW'(1);
                    end
                end
                DET_LOW1: begin
                    if (!pin_q) begin
                        if (low_cnt_q != LOW_SAT) low_cnt_d = low_cnt_q + 1'b1;
                    end else if (low_cnt_q == LOW_SAT) begin
                        state_d    = DET_HIGH;
                        high_cnt_d = HW'(1);
                    end else begin
                        state_d = DET_IDLE;
                    end
                end
                DET_HIGH: begin
                    if (pin_q) begin
                        if (high_cnt_q == HIGH_HI) state_d = DET_IDLE;
                        else                       high_cnt_d = high_cnt_q + 1'b1;
                    end else if (high_cnt_q >= HIGH_LO) begin
                        state_d   = DET_LOW2;
                        low_cnt_d = LW'(1);
                    end else begin
                        state_d = DET_IDLE;
                    end
                end
                DET_LOW2: begin
                    if (!pin_q) begin
                        if (low_cnt_q != LOW_SAT) low_cnt_d = low_cnt_q + 1'b1;
                    end else if (low_cnt_q == LOW_SAT) begin
                        state_d   = DET_COUNT;
                        rel_cnt_d = '0;
                    end else begin
                        state_d = DET_IDLE;
                    end
                end
                DET_COUNT: begin
                    if (rel_cnt_q == REL_LAST) state_d = DET_IDLE;
                    else                       rel_cnt_d = rel_cnt_q + 1'b1;
                end
                default: state_d = DET_IDLE;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= DET_IDLE;
            low_cnt_q  <= '0;
            high_cnt_q <= '0;
            rel_cnt_q  <= '0;
        end else begin
            state_q    <= state_d;
            low_cnt_q  <= low_cnt_d;
            high_cnt_q <= high_cnt_d;
            rel_cnt_q  <= rel_cnt_d;
        end
    end

    assign hold_o    = (state_q == DET_COUNT);
    assign restart_o = (state_q == DET_COUNT) && (rel_cnt_q == REL_LAST) && master_en;

    // Flag the cycle that follows the restart edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= restart_o;
    end

    assign done_o = done_q;

    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_HIGH) |-> (high_cnt_q <= HIGH_HI)); // R5
    AST_COUNT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_COUNT && $past(state_q) != DET_COUNT) |->
        ($past(state_q) == DET_LOW2 && $past(low_cnt_q) == LOW_SAT && $past(pin_q))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_COUNT) |-> (rel_cnt_q <= REL_LAST)); // R7
    AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (state_q == DET_IDLE)); // R10
    AST_LOW1_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_LOW1 && $past(state_q) == DET_IDLE) |-> !$past(pin_q)); // R4

endmodule

// File: rtl/clk_phase_div.sv
// Module: clk_phase_div
// A free-running phase counter over one sample period of MCLK_PER_FS
// master clocks. The word clock, bit clock and modulator enable are all
// decoded from it. hold parks the clocks high and keeps the counter at
// zero. restart forces the counter to zero, so that the next period
// begins at the left-channel half.
// Assumes: MCLK_PER_FS, BCLK_DIV and MOD_DIV are powers of two, each >= 2.
module clk_phase_div #(
    parameter int MCLK_PER_FS = 256,
    parameter int BCLK_DIV    = 4,
    parameter int MOD_DIV     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic restart,
    output logic mod_ce,
    output logic wclk,
    output logic bclk
);

    localparam int CW = $clog2(MCLK_PER_FS);
    localparam int BB = $clog2(BCLK_DIV) - 1;
    localparam int MW = $clog2(MOD_DIV);

    logic [CW-1:0] phase_q;
    logic          mod_tick;

    // Advance the phase; park at zero while held or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || restart) phase_q <= '0;
        else                           phase_q <= phase_q + 1'b1;
    end

    // Modulator enable on the last count of each modulator period.
    generate
        if (MW > 0) begin : g_mod_dec
            assign mod_tick = &phase_q[MW-1:0];
        end else begin : g_mod_every
            assign mod_tick = 1'b1;
        end
    endgenerate

    assign mod_ce = !hold && mod_tick;
    assign wclk   = hold | phase_q[CW-1];
    assign bclk   = hold | phase_q[BB];

    AST_MODCE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ce && !hold) |=> !mod_ce); // R3
    AST_WCLK_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !wclk); // R7

endmodule

// File: rtl/audio_sync_clkgen.sv
// Module: audio_sync_clkgen
// Top level. The sync pin pattern detector drives the hold and restart
// controls of the clock divider. Outputs come straight from the divider,
// and the done flag comes from the detector.
// Assumes: clk is the 256x sample-rate master clock, and all inputs are
// synchronous to it.
module audio_sync_clkgen #(
    parameter int MCLK_PER_FS  = 256,
    parameter int BCLK_DIV     = 4,
    parameter int MOD_DIV      = 4,
    parameter int LOW_MIN      = 4,
    parameter int HIGH_MIN     = 1,
    parameter int HIGH_MAX     = 2,
    parameter int SYNC_LATENCY = 127
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic sync_pin_n,
    output logic mod_ce,
    output logic wclk,
    output logic bclk,
    output logic sync_done
);

    logic hold;
    logic restart;

    sync_seq_detect #(
        .LOW_MIN      (LOW_MIN),
        .HIGH_MIN     (HIGH_MIN),
        .HIGH_MAX     (HIGH_MAX),
        .SYNC_LATENCY (SYNC_LATENCY)
    ) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .pin_n     (sync_pin_n),
        .hold_o    (hold),
        .restart_o (restart),
        .done_o    (sync_done)
    );

    clk_phase_div #(
        .MCLK_PER_FS (MCLK_PER_FS),
        .BCLK_DIV    (BCLK_DIV),
        .MOD_DIV     (MOD_DIV)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .restart (restart),
        .mod_ce  (mod_ce),
        .wclk    (wclk),
        .bclk    (bclk)
    );

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (wclk && bclk && !mod_ce)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> !sync_done); // R8
    AST_DONE_WCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> !wclk); // R8

endmodule

// File: tb/audio_sync_clkgen_tb.sv
`timescale 1ns/1ps
module audio_sync_clkgen_tb_top;

    typedef struct packed {
        logic [7:0] l1;
        logic [7:0] hi;
        logic [7:0] l2;
        logic       m;
        logic       exp_sync;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'd4,  8'd1, 8'd4, 1'b1, 1'b1},
        '{8'd4,  8'd2, 8'd4, 1'b1, 1'b1},
        '{8'd6,  8'd2, 8'd9, 1'b1, 1'b1},
        '{8'd3,  8'd1, 8'd4, 1'b1, 1'b0},
        '{8'd4,  8'd3, 8'd4, 1'b1, 1'b0},
        '{8'd4,  8'd1, 8'd3, 1'b1, 1'b0},
        '{8'd4,  8'd1, 8'd4, 1'b0, 1'b0},
        '{8'd10, 8'd1, 8'd5, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b1;
    logic sync_pin_n = 1'b1;
    logic mod_ce, wclk, bclk, sync_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fall_last = -1, fall_prev = -1, rise_last = -1;
    int sd_count = 0, bclk_rises = 0, ce_count = 0;
    logic wclk_prev = 1'b0, bclk_prev = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    audio_sync_clkgen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .sync_pin_n (sync_pin_n),
        .mod_ce     (mod_ce),
        .wclk       (wclk),
        .bclk       (bclk),
        .sync_done  (sync_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Observe the outputs between clock edges.
    always @(negedge clk) begin
        if (wclk_prev && !wclk) begin fall_prev = fall_last; fall_last = cyc; end
        if (!wclk_prev && wclk) rise_last = cyc;
        if (!bclk_prev && bclk) bclk_rises++;
        if (mod_ce) ce_count++;
        if (sync_done) sd_count++;
        wclk_prev = wclk;
        bclk_prev = bclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R4 R5 R6 R7";
            1: return "R5 R7";
            2: return "R4 R6 R7";
            3: return "R4 R9";
            4: return "R5 R9";
            5: return "R6 R9";
            6: return "R10";
            default: return "R7 R8";
        endcase
    endfunction

    task automatic run_vec(input int i);
        vec_t v;
        int ref_fall, sd0;
        string tag;
        v = VECS[i];
        tag = row_tag(i);
        @(negedge clk);
        master_en = v.m;
        sync_pin_n = 1'b1;
        repeat (8) @(negedge clk);
        ref_fall = fall_last;
        sd0 = sd_count;
        sync_pin_n = 1'b0;
        repeat (int'(v.l1)) @(negedge clk);
        sync_pin_n = 1'b1;
        repeat (int'(v.hi)) @(negedge clk);
        sync_pin_n = 1'b0;
        repeat (int'(v.l2)) @(negedge clk);
        sync_pin_n = 1'b1;
        if (v.exp_sync) begin
            repeat (127) @(negedge clk);
            chk(wclk && bclk && !mod_ce, tag, {wclk, bclk, mod_ce}, 3'b110, "parked at edge n+126");
            @(negedge clk);
            chk(!wclk, tag, wclk, 0, "wclk low after edge n+127");
            chk(sync_done, "R8", sync_done, 1, "sync_done after edge n+127");
            @(negedge clk);
            chk(!sync_done, "R8", sync_done, 0, "sync_done one cycle only");
            repeat (126) @(negedge clk);
            chk(!wclk, "R2", wclk, 0, "wclk low at count 127");
            @(negedge clk);
            chk(wclk, "R2", wclk, 1, "wclk high at count 128");
        end else begin
            repeat (300) @(negedge clk);
            chk(sd_count == sd0, tag, sd_count - sd0, 0, "sync_done pulses");
            chk(fall_last != ref_fall && ((fall_last - ref_fall) % 256) == 0, tag,
                (fall_last - ref_fall) % 256, 0, "phase shift modulo 256");
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        done_flag = 1'b1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sd0, b0, c0;
        repeat (3) @(negedge clk);
        chk(!wclk && !bclk && !mod_ce && !sync_done, "R1",
            {wclk, bclk, mod_ce, sync_done}, 0, "outputs in reset");
        rst_n = 1'b1;
        repeat (600) @(negedge clk);
        chk(fall_last - fall_prev == 256, "R2", fall_last - fall_prev, 256, "wclk period");
        chk(((rise_last - fall_last + 256) % 256) == 128, "R2",
            (rise_last - fall_last + 256) % 256, 128, "wclk low half");
        b0 = bclk_rises;
        c0 = ce_count;
        repeat (256) @(negedge clk);
        chk(bclk_rises - b0 == 64, "R3", bclk_rises - b0, 64, "bclk rises per period");
        chk(ce_count - c0 == 64, "R3", ce_count - c0, 64, "mod_ce per period");
        for (int k = 0; k < 8; k++) begin
            if (mod_ce) chk(bclk, "R3", bclk, 1, "mod_ce while bclk high");
            @(negedge clk);
        end

        for (int i = 0; i < NV; i++) run_vec(i);

        // Reset in the middle of a countdown abandons it.
        master_en = 1'b1;
        sync_pin_n = 1'b0; repeat (4) @(negedge clk);
        sync_pin_n = 1'b1; @(negedge clk);
        sync_pin_n = 1'b0; repeat (4) @(negedge clk);
        sync_pin_n = 1'b1; repeat (40) @(negedge clk);
        chk(wclk && bclk, "R7", {wclk, bclk}, 3, "parked during countdown");
        sd0 = sd_count;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!wclk && !bclk && !mod_ce && !sync_done, "R1",
            {wclk, bclk, mod_ce, sync_done}, 0, "outputs after mid-sequence reset");
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        chk(sd_count == sd0, "R1", sd_count - sd0, 0, "countdown abandoned by reset");

        if (!done_flag) begin
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule